// File: doc/BRIEF.md
# Multi-format serial audio receiver

This block takes stereo PCM audio from a three-wire serial port (a bit clock, a word clock that marks the left and right halves of each frame, and one data line). It turns each frame into a pair of parallel 24-bit signed samples in a separate system-clock domain, with a one-cycle valid strobe per pair. Four static mode pins choose the framing together: I2S, left-justified, or right-justified with 16-bit or 24-bit words. The same pins also pick stereo or single-channel output. They set a rolloff flag and a filter-bypass flag, which the block only reports to downstream logic.

Serial data is shifted in on the rising edge of the bit clock, in that clock's own domain. When a frame's right word ends, the pair is parked in holding registers and a toggle flips. The system-clock side synchronises the toggle, sees the change, and copies the pair out. The bit clock and word clock must be frequency-locked to the system clock, but their phase against it is free.

Top module: `audio_serial_rx`

## Requirements
- R1: While reset is asserted, and until the first pair is delivered, `left_o` and `right_o` are zero and `valid_o` is low.
- R2: Framing code 00 is I2S. `wclk_i` low marks the left word. The MSB is sampled on the second rising bit-clock edge after a word-clock change. The first 24 bits of each half are the sample, and later bits in that half are ignored.
- R3: Framing code 01 is left-justified. `wclk_i` high marks the left word. The MSB is sampled on the first rising bit-clock edge that sees the new word-clock level. The first 24 bits are the sample, and later bits are ignored.
- R4: Framing code 11 is right-justified 24-bit. `wclk_i` high marks the left word. The sample is the last 24 bits sampled before the word-clock change, and earlier bits in the half are ignored.
- R5: Framing code 10 is right-justified 16-bit. The sample is the last 16 bits before the word-clock change, sign-extended to 24 bits.
- R6: With `mono_i` low and `chsel_i` high, framing codes 00, 01 and 10 keep the meaning of R2, R3 and R5, `slow_roll_o` is high and `bypass_o` is low. In every other pin combination except R7, `slow_roll_o` is low.
- R7: With `mono_i` low, `chsel_i` high and code 11, `bypass_o` is high. Framing follows R4 and output stays stereo. In every other combination, `bypass_o` is low.
- R8: With `mono_i` high, `mono_o` is high and `mono_right_o` equals `chsel_i`. Both outputs carry the left sample when `chsel_i` is 0, and the right sample when it is 1. With `mono_i` low, both flags are low and the outputs are the left and right samples.
- R9: `valid_o` pulses for exactly one cycle per frame whose left word was followed by its right word. The right word ends at the word-clock change that follows it. The word before the first word-clock change after reset, and a right word with no complete left word before it, are dropped. Outputs change only together with `valid_o`.
- R10: With the bit clock rising between system-clock edges, `valid_o` and the pair appear on the third rising system-clock edge after the bit-clock edge that samples the word-clock change ending the right word.
- R11: The flags `mono_o`, `mono_right_o`, `slow_roll_o` and `bypass_o` follow the mode pins one system clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset, both domains |
| bclk_i | input | 1 | Serial bit clock |
| wclk_i | input | 1 | Word clock, left/right half marker |
| sdata_i | input | 1 | Serial data, MSB first, two's complement |
| fmt_i | input | 2 | Framing code |
| chsel_i | input | 1 | Rolloff/bypass select, or mono source when mono is set |
| mono_i | input | 1 | Single-channel output select |
| left_o | output | 24 | Left (or mono) sample |
| right_o | output | 24 | Right (or mono) sample |
| valid_o | output | 1 | One-cycle strobe for a new pair |
| mono_o | output | 1 | Mono mode flag |
| mono_right_o | output | 1 | Mono source is the right channel |
| slow_roll_o | output | 1 | Slow rolloff requested |
| bypass_o | output | 1 | Filter bypass requested |

## Verification
Every pin combination that changes framing or channel mapping is streamed with 32-bit slots. The bits outside each format's 24 or 16 data positions are filled with random values, so a receiver that counts from the wrong edge or at the wrong offset picks up noise instead of the sample. Full-scale positive, full-scale negative, zero and all-ones words sit in fixed frames to expose sign-extension and bit-order faults. Mono-left and mono-right cases with different left and right words separate the two duplication paths. The strobe is compared against a predicted cycle on every clock, so a missing, doubled or late pulse is caught as well as wrong data.

// File: rtl/asrx_pkg.sv
package asrx_pkg;

    typedef enum logic [1:0] {
        FRM_I2S     = 2'b00,
        FRM_LEFT    = 2'b01,
        FRM_RIGHT16 = 2'b10,
        FRM_RIGHT24 = 2'b11
    } frame_e;

    typedef struct packed {
        frame_e frame;
        logic   mono;
        logic   mono_right;
        logic   slow_roll;
        logic   bypass;
    } mode_t;

endpackage

// File: rtl/asrx_mode_dec.sv
module asrx_mode_dec
    import asrx_pkg::*;
(
    input  logic [1:0] fmt_i,
    input  logic       chsel_i,
    input  logic       mono_i,
    output mode_t      mode_o
);

    always_comb begin
        mode_o            = '0;
        mode_o.frame      = frame_e'(fmt_i);
        mode_o.mono       = mono_i;
        mode_o.mono_right = mono_i & chsel_i;
        mode_o.bypass     = ~mono_i & chsel_i & (fmt_i == 2'b11);
        mode_o.slow_roll  = ~mono_i & chsel_i & (fmt_i != 2'b11);
    end

endmodule

// File: rtl/asrx_deser.sv
module asrx_deser
    import asrx_pkg::*;
#(
    parameter int DATA_W  = 24,
    parameter int SHORT_W = 16
) (
    input  logic              bclk_i,
    input  logic              rst_ni,
    input  logic              wclk_i,
    input  logic              sdata_i,
    input  frame_e            frame_i,
    output logic [DATA_W-1:0] pair_l_o,
    output logic [DATA_W-1:0] pair_r_o,
    output logic              tgl_o
);

    localparam int CNT_W = $clog2(DATA_W + 1);
    localparam int EXT_W = DATA_W - SHORT_W;

    typedef struct packed {
        logic              started;
        logic              synced;
        logic              wclk;
        logic [CNT_W-1:0]  cnt;
        logic [DATA_W-1:0] acc;
        logic [DATA_W-1:0] hist;
        logic [DATA_W-1:0] left;
        logic              have_left;
        logic [DATA_W-1:0] pair_l;
        logic [DATA_W-1:0] pair_r;
        logic              tgl;
    } deser_t;

    deser_t s_d, s_q;

    logic              edge_seen;
    logic              left_end;
    logic              room;
    logic [DATA_W-1:0] acc_next;
    logic [DATA_W-1:0] word;

    always_comb begin
        s_d       = s_q;
        edge_seen = s_q.started && (wclk_i != s_q.wclk);
        left_end  = (frame_i == FRM_I2S) ? ~s_q.wclk : s_q.wclk;
        room      = s_q.cnt < CNT_W'(DATA_W);
        acc_next  = {s_q.acc[DATA_W-2:0], sdata_i};

        unique case (frame_i)
            FRM_I2S:     word = room ? acc_next : s_q.acc;
            FRM_LEFT:    word = s_q.acc;
            FRM_RIGHT16: word = {{EXT_W{s_q.hist[SHORT_W-1]}}, s_q.hist[SHORT_W-1:0]};
            default:     word = s_q.hist;
        endcase

        s_d.started = 1'b1;
        s_d.wclk    = wclk_i;
        s_d.hist    = {s_q.hist[DATA_W-2:0], sdata_i};

        if (edge_seen) begin
            s_d.synced = 1'b1;
            if (s_q.synced) begin
                if (left_end) begin
                    s_d.left      = word;
                    s_d.have_left = 1'b1;
                end else if (s_q.have_left) begin
                    s_d.pair_l    = s_q.left;
                    s_d.pair_r    = word;
                    s_d.tgl       = ~s_q.tgl;
                    s_d.have_left = 1'b0;
                end
            end
            if (frame_i == FRM_I2S) begin
                s_d.acc = '0;
                s_d.cnt = '0;
            end else begin
                s_d.acc = {{(DATA_W-1){1'b0}}, sdata_i};
                s_d.cnt = CNT_W'(1);
            end
        end else if (room) begin
            s_d.acc = acc_next;
            s_d.cnt = s_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge bclk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign pair_l_o = s_q.pair_l;
    assign pair_r_o = s_q.pair_r;
    assign tgl_o    = s_q.tgl;

endmodule

// File: rtl/asrx_xfer.sv
module asrx_xfer #(
    parameter int DATA_W   = 24,
    parameter int SYNC_LEN = 2
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [DATA_W-1:0] pair_l_i,
    input  logic [DATA_W-1:0] pair_r_i,
    input  logic              tgl_i,
    input  logic              mono_i,
    input  logic              mono_right_i,
    input  logic              slow_roll_i,
    input  logic              bypass_i,
    output logic [DATA_W-1:0] left_o,
    output logic [DATA_W-1:0] right_o,
    output logic              valid_o,
    output logic              mono_o,
    output logic              mono_right_o,
    output logic              slow_roll_o,
    output logic              bypass_o
);

    typedef struct packed {
        logic [SYNC_LEN:0] sync;
        logic              mono;
        logic              mono_right;
        logic              slow_roll;
        logic              bypass;
        logic [DATA_W-1:0] left;
        logic [DATA_W-1:0] right;
        logic              valid;
    } xfer_t;

    xfer_t s_d, s_q;

    logic              fire;
    logic [DATA_W-1:0] mono_pick;

    always_comb begin
        s_d            = s_q;
        s_d.sync       = {s_q.sync[SYNC_LEN-1:0], tgl_i};
        s_d.mono       = mono_i;
        s_d.mono_right = mono_right_i;
        s_d.slow_roll  = slow_roll_i;
        s_d.bypass     = bypass_i;
        s_d.valid      = 1'b0;
        fire           = s_q.sync[SYNC_LEN-1] ^ s_q.sync[SYNC_LEN];
        mono_pick      = s_q.mono_right ? pair_r_i : pair_l_i;

        if (fire) begin
            s_d.valid = 1'b1;
            if (s_q.mono) begin
                s_d.left  = mono_pick;
                s_d.right = mono_pick;
            end else begin
                s_d.left  = pair_l_i;
                s_d.right = pair_r_i;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign left_o       = s_q.left;
    assign right_o      = s_q.right;
    assign valid_o      = s_q.valid;
    assign mono_o       = s_q.mono;
    assign mono_right_o = s_q.mono_right;
    assign slow_roll_o  = s_q.slow_roll;
    assign bypass_o     = s_q.bypass;

endmodule

// File: rtl/audio_serial_rx.sv
module audio_serial_rx
    import asrx_pkg::*;
#(
    parameter int DATA_W   = 24,
    parameter int SHORT_W  = 16,
    parameter int SYNC_LEN = 2
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              bclk_i,
    input  logic              wclk_i,
    input  logic              sdata_i,
    input  logic [1:0]        fmt_i,
    input  logic              chsel_i,
    input  logic              mono_i,
    output logic [DATA_W-1:0] left_o,
    output logic [DATA_W-1:0] right_o,
    output logic              valid_o,
    output logic              mono_o,
    output logic              mono_right_o,
    output logic              slow_roll_o,
    output logic              bypass_o
);

    mode_t             mode;
    logic [DATA_W-1:0] pair_l;
    logic [DATA_W-1:0] pair_r;
    logic              tgl;

    asrx_mode_dec u_dec (
        .fmt_i   (fmt_i),
        .chsel_i (chsel_i),
        .mono_i  (mono_i),
        .mode_o  (mode)
    );

    asrx_deser #(
        .DATA_W  (DATA_W),
        .SHORT_W (SHORT_W)
    ) u_deser (
        .bclk_i   (bclk_i),
        .rst_ni   (rst_ni),
        .wclk_i   (wclk_i),
        .sdata_i  (sdata_i),
        .frame_i  (mode.frame),
        .pair_l_o (pair_l),
        .pair_r_o (pair_r),
        .tgl_o    (tgl)
    );

    asrx_xfer #(
        .DATA_W   (DATA_W),
        .SYNC_LEN (SYNC_LEN)
    ) u_xfer (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .pair_l_i     (pair_l),
        .pair_r_i     (pair_r),
        .tgl_i        (tgl),
        .mono_i       (mode.mono),
        .mono_right_i (mode.mono_right),
        .slow_roll_i  (mode.slow_roll),
        .bypass_i     (mode.bypass),
        .left_o       (left_o),
        .right_o      (right_o),
        .valid_o      (valid_o),
        .mono_o       (mono_o),
        .mono_right_o (mono_right_o),
        .slow_roll_o  (slow_roll_o),
        .bypass_o     (bypass_o)
    );

endmodule

// File: rtl/audio_serial_rx_chk.sv
module audio_serial_rx_chk #(
    parameter int DATA_W  = 24,
    parameter int SHORT_W = 16
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic [1:0]        fmt_i,
    input logic              chsel_i,
    input logic              mono_i,
    input logic [DATA_W-1:0] left_o,
    input logic [DATA_W-1:0] right_o,
    input logic              valid_o,
    input logic              mono_o,
    input logic              mono_right_o,
    input logic              slow_roll_o,
    input logic              bypass_o
);

    // R9: strobe lasts one cycle
    a_r9_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
        valid_o |=> !valid_o);

    // R9: outputs only move together with the strobe
    a_r9_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !valid_o |-> ($stable(left_o) && $stable(right_o)));

    // R8: mono delivers the same word on both outputs
    a_r8_mono_dup: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (valid_o && mono_o) |-> (left_o == right_o));

    // R8: right-source flag implies mono
    a_r8_right_needs_mono: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mono_right_o |-> mono_o);

    // R5: short words arrive sign-extended
    a_r5_sign_ext: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (valid_o && fmt_i == 2'b10) |->
        ((&left_o[DATA_W-1:SHORT_W-1]) || !(|left_o[DATA_W-1:SHORT_W-1])));

    // R6 and R7: rolloff and bypass flags never together
    a_r6_flag_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(slow_roll_o && bypass_o));

    // R11: bypass pin combination reported one cycle later
    a_r11_bypass_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!mono_i && chsel_i && fmt_i == 2'b11) |=> bypass_o);

endmodule

bind audio_serial_rx audio_serial_rx_chk #(
    .DATA_W  (DATA_W),
    .SHORT_W (SHORT_W)
) u_chk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .fmt_i        (fmt_i),
    .chsel_i      (chsel_i),
    .mono_i       (mono_i),
    .left_o       (left_o),
    .right_o      (right_o),
    .valid_o      (valid_o),
    .mono_o       (mono_o),
    .mono_right_o (mono_right_o),
    .slow_roll_o  (slow_roll_o),
    .bypass_o     (bypass_o)
);

// File: tb/tb_audio_serial_rx.sv
module tb_audio_serial_rx;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bclk = 1'b0;
    logic        wclk = 1'b0;
    logic        sdata = 1'b0;
    logic [1:0]  fmt = 2'b00;
    logic        chsel = 1'b0;
    logic        mono = 1'b0;
    logic [23:0] left_o, right_o;
    logic        valid_o, mono_o, mono_right_o, slow_roll_o, bypass_o;

    always #2 clk = ~clk;

    audio_serial_rx dut (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .bclk_i       (bclk),
        .wclk_i       (wclk),
        .sdata_i      (sdata),
        .fmt_i        (fmt),
        .chsel_i      (chsel),
        .mono_i       (mono),
        .left_o       (left_o),
        .right_o      (right_o),
        .valid_o      (valid_o),
        .mono_o       (mono_o),
        .mono_right_o (mono_right_o),
        .slow_roll_o  (slow_roll_o),
        .bypass_o     (bypass_o)
    );

    int n_chk = 0;
    int n_err = 0;
    int negs  = 0;
    bit done  = 0;

    bit          run = 0;
    int          fi, si, ph, nfr;
    logic        lvl;
    logic [23:0] fl [8];
    logic [23:0] fr [8];
    bit          cmono, cchsel;
    string       ctag;

    int          q_due [$];
    logic [23:0] q_l [$];
    logic [23:0] q_r [$];

    int          half, slot;
    logic [23:0] cw;

    function automatic logic slot_bit(int s, logic [23:0] w, logic [1:0] f);
        case (f)
            2'b00: if (s >= 1 && s <= 24) return w[24-s];
            2'b01: if (s <= 23) return w[23-s];
            2'b10: if (s >= 16) return w[31-s];
            default: if (s >= 8) return w[31-s];
        endcase
        return 1'($urandom_range(0, 1));
    endfunction

    task automatic check_bit(string tag, logic act, logic exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        negs++;
        if (q_due.size() > 0 && q_due[0] < negs) begin
            n_chk++; n_err++;
            $display("FAIL R10 strobe missing actual=0 expected=1 (due %0d)", q_due[0]);
            void'(q_due.pop_front()); void'(q_l.pop_front()); void'(q_r.pop_front());
        end
        if (valid_o) begin
            if (q_due.size() > 0 && q_due[0] == negs) begin
                n_chk++;
                if (left_o !== q_l[0] || right_o !== q_r[0]) begin
                    n_err++;
                    $display("FAIL %s actual=%h/%h expected=%h/%h", ctag,
                             left_o, right_o, q_l[0], q_r[0]);
                end
                void'(q_due.pop_front()); void'(q_l.pop_front()); void'(q_r.pop_front());
            end else begin
                n_chk++; n_err++;
                $display("FAIL R9 unexpected strobe actual=1 expected=0 at %0d", negs);
            end
        end else if (q_due.size() > 0 && q_due[0] == negs) begin
            n_chk++; n_err++;
            $display("FAIL R10 strobe late actual=0 expected=1 at %0d", negs);
            void'(q_due.pop_front()); void'(q_l.pop_front()); void'(q_r.pop_front());
        end

        if (run) begin
            if (ph == 0) begin
                bclk  = 1'b0;
                half  = si / 32;
                slot  = si % 32;
                cw    = (half != 0) ? fr[fi] : fl[fi];
                wclk  = (half != 0) ? ~lvl : lvl;
                sdata = slot_bit(slot, cw, fmt);
            end else if (ph == 4) begin
                bclk = 1'b1;
                if (si == 0 && fi >= 2) begin
                    q_due.push_back(negs + 3);
                    if (cmono && !cchsel) begin
                        q_l.push_back(fl[fi-1]); q_r.push_back(fl[fi-1]);
                    end else if (cmono) begin
                        q_l.push_back(fr[fi-1]); q_r.push_back(fr[fi-1]);
                    end else begin
                        q_l.push_back(fl[fi-1]); q_r.push_back(fr[fi-1]);
                    end
                end
            end
            ph++;
            if (ph == 8) begin
                ph = 0;
                si++;
                if (si == 64) begin
                    si = 0;
                    fi++;
                    if (fi == nfr) run = 0;
                end
            end
        end
    end

    task automatic run_case(string tag, bit m, bit c, logic [1:0] f);
        logic [15:0] v;
        @(negedge clk);
        rst_n = 1'b0;
        bclk  = 1'b0;
        mono  = m; chsel = c; fmt = f;
        cmono = m; cchsel = c; ctag = tag;
        repeat (3) @(negedge clk);
        // R1: reset state
        check_bit("R1 valid in reset", valid_o, 1'b0);
        check_bit("R1 left zero in reset", left_o == 24'd0, 1'b1);
        check_bit("R1 right zero in reset", right_o == 24'd0, 1'b1);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        // R11 with R6, R7, R8: flags follow pins
        check_bit("R8 mono flag", mono_o, m);
        check_bit("R8 mono_right flag", mono_right_o, m & c);
        check_bit("R6 slow flag", slow_roll_o, !m && c && f != 2'b11);
        check_bit("R7 bypass flag", bypass_o, !m && c && f == 2'b11);
        check_bit("R1 no strobe after reset", valid_o, 1'b0);

        nfr = 6;
        for (int k = 0; k < nfr; k++) begin
            if (f == 2'b10) begin
                v = 16'($urandom); fl[k] = {{8{v[15]}}, v};
                v = 16'($urandom); fr[k] = {{8{v[15]}}, v};
            end else begin
                fl[k] = 24'($urandom);
                fr[k] = 24'($urandom);
            end
        end
        if (f == 2'b10) begin
            fl[1] = 24'hFF8000; fr[1] = 24'h007FFF;
        end else begin
            fl[1] = 24'h800000; fr[1] = 24'h7FFFFF;
        end
        fl[2] = 24'h000000; fr[2] = 24'hFFFFFF;

        lvl = (f == 2'b00) ? 1'b0 : 1'b1;
        fi = 0; si = 0; ph = 0;
        run = 1;
        while (run) @(negedge clk);
        repeat (8) @(negedge clk);
        while (q_due.size() > 0) begin
            n_chk++; n_err++;
            $display("FAIL R9 pair never delivered actual=none expected=%h/%h", q_l[0], q_r[0]);
            void'(q_due.pop_front()); void'(q_l.pop_front()); void'(q_r.pop_front());
        end
    endtask

    initial begin
        run_case("R2 i2s data", 1'b0, 1'b0, 2'b00);
        run_case("R3 left-justified data", 1'b0, 1'b0, 2'b01);
        run_case("R5 rj16 data", 1'b0, 1'b0, 2'b10);
        run_case("R4 rj24 data", 1'b0, 1'b0, 2'b11);
        run_case("R6 slow i2s data", 1'b0, 1'b1, 2'b00);
        run_case("R6 slow rj16 data", 1'b0, 1'b1, 2'b10);
        run_case("R7 bypass data", 1'b0, 1'b1, 2'b11);
        run_case("R8 mono-left data", 1'b1, 1'b0, 2'b01);
        run_case("R8 mono-right i2s data", 1'b1, 1'b1, 2'b00);
        run_case("R8 mono-right rj24 data", 1'b1, 1'b1, 2'b11);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL R9 watchdog expired actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

endmodule